// File: doc/BRIEF.md
# Stereo Level Converter with Stepped Fade

This block is a per-sample gain stage that sits in a stereo audio path. A single-cycle strobe marks each new left/right sample pair. On that strobe the block scales both samples by one shared gain and registers the result. It then moves its gain state according to the command inputs. The gain is an index into a constant table of logarithmically spaced coefficients. The top entry is unity. The bottom entry is silence. Adjacent entries are about 0.07 dB apart.

Level inputs drive the commands, and the block samples them on each strobe. Mute ramps the index down one step per strobe until it reaches silence. Full scale ramps the index back up to unity and drops any attenuation. Attenuate switches in a fixed extra -12 dB scale. Fade up and fade down move the index one step. A separate peak meter keeps the largest absolute input value seen on each channel. It reports the top 8 bits of that value and holds it until a clear.

Top module: `audio_gain_stage`

## Requirements
- R1: While reset is held, and after it is released, the gain index is 127, attenuation is off, both sample outputs are 0 and both peak outputs are 0.
- R2: The gain index changes only on a cycle where strobe_i is high, and by at most one step. It saturates at 0 and at 127, so it never wraps.
- R3: A strobe with mute_i high lowers the index by one unless it is already 0. Index 0 has coefficient 0, so the outputs are exactly 0 after the next strobe.
- R4: A strobe with full_i high, and with mute_i and atten_i low, raises the index by one unless it is already 127. It also turns attenuation off.
- R5: A strobe with atten_i high and mute_i low turns attenuation on and leaves the index unchanged. While attenuation is on, each scaled sample y is scaled again to (y*8231 + 16384) >>> 15, which is -12 dB.
- R6: A strobe where only fade commands are active raises the index when fade_up_i is high and lowers it when only fade_dn_i is high. When both are high, up wins.
- R7: When several commands are high on one strobe, only the highest one acts. The order is mute, then attenuate, then full scale, then fade.
- R8: The coefficient table is c[127]=32768, c[k-1]=(c[k]*65010+32768)>>16 for k from 127 down to 2, and c[0]=0. On a strobe each output becomes (x*c[g] + 16384) >>> 15, where g and the attenuation state are the values from before that strobe's update. Left and right use the same gain. The outputs hold between strobes.
- R9: On a strobe, each channel's peak register takes the larger of its stored value and the absolute value of the input sample. The absolute value of -32768 is 32768. The peak output is bits [15:8] of the register.
- R10: pk_clr_i zeroes both peak registers on the next edge. This takes priority over a peak update on the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| strobe_i | input | 1 | New sample pair present |
| left_i | input | 16 | Signed left sample |
| right_i | input | 16 | Signed right sample |
| mute_i | input | 1 | Ramp toward silence |
| full_i | input | 1 | Ramp toward unity, drop attenuation |
| atten_i | input | 1 | Enable fixed -12 dB |
| fade_up_i | input | 1 | One step up |
| fade_dn_i | input | 1 | One step down |
| pk_clr_i | input | 1 | Clear both peak registers |
| left_o | output | 16 | Scaled left sample |
| right_o | output | 16 | Scaled right sample |
| gain_o | output | 7 | Current gain index |
| peak_l_o | output | 8 | Left peak, top 8 bits |
| peak_r_o | output | 8 | Right peak, top 8 bits |

## Verification
A wrong gain index or a wrong priority decision shows up on gain_o at the edge after the strobe. It also changes the scaled samples on the strobe that follows, so a per-cycle comparison catches it within two strobes. A wrong attenuation flag stays hidden until the next strobe carries a nonzero sample. A wrong peak register shows on the peak outputs only when the error reaches the top 8 bits. For that reason the bench drives full-range values, including -32768, and a clear on the same cycle as a strobe.

// File: rtl/audio_gain_stage.sv
module audio_gain_stage #(
  parameter int DW     = 16,
  parameter int STEPS  = 128,
  parameter int FADE_K = 65010,
  parameter int ATT_K  = 8231
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       strobe_i,
  input  logic signed [DW-1:0]       left_i,
  input  logic signed [DW-1:0]       right_i,
  input  logic                       mute_i,
  input  logic                       full_i,
  input  logic                       atten_i,
  input  logic                       fade_up_i,
  input  logic                       fade_dn_i,
  input  logic                       pk_clr_i,
  output logic signed [DW-1:0]       left_o,
  output logic signed [DW-1:0]       right_o,
  output logic [$clog2(STEPS)-1:0]   gain_o,
  output logic [7:0]                 peak_l_o,
  output logic [7:0]                 peak_r_o
);
  localparam int GW = $clog2(STEPS);
  localparam int PW = DW + 18;
  localparam logic [GW-1:0] TOP = GW'(STEPS - 1);

  function automatic logic [15:0] coef(input int k);
    longint c = 32768;
    for (int i = STEPS - 1; i > k; i--) c = (c * FADE_K + 32768) >>> 16;
    return (k == 0) ? 16'd0 : 16'(c);
  endfunction

  function automatic logic signed [DW-1:0] mul(input logic signed [DW-1:0] x,
                                               input logic [15:0] c);
    logic signed [PW-1:0] p;
    p = $signed(PW'(x)) * $signed(PW'({1'b0, c})) + $signed(PW'(16384));
    return p[DW+14:15];
  endfunction

  logic [15:0] rom [STEPS];
  for (genvar k = 0; k < STEPS; k++) begin : g_rom
    assign rom[k] = coef(k);
  end

  logic [GW-1:0] g;
  logic          att;
  logic [DW-1:0] pk_l, pk_r;

  wire [15:0] c_now = rom[g];
  wire signed [DW-1:0] l1 = mul(left_i, c_now);
  wire signed [DW-1:0] r1 = mul(right_i, c_now);
  wire signed [DW-1:0] l2 = att ? mul(l1, 16'(ATT_K)) : l1;
  wire signed [DW-1:0] r2 = att ? mul(r1, 16'(ATT_K)) : r1;
  wire [DW-1:0] abs_l = left_i[DW-1]  ? ~left_i + 1'b1  : left_i;
  wire [DW-1:0] abs_r = right_i[DW-1] ? ~right_i + 1'b1 : right_i;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      g <= TOP; att <= 1'b0;
      left_o <= '0; right_o <= '0;
      pk_l <= '0; pk_r <= '0;
    end else begin
      if (pk_clr_i) begin
        pk_l <= '0; pk_r <= '0;
      end else if (strobe_i) begin
        if (abs_l > pk_l) pk_l <= abs_l;
        if (abs_r > pk_r) pk_r <= abs_r;
      end
      if (strobe_i) begin
        left_o <= l2; right_o <= r2;
        if (mute_i) begin
          if (g != '0) g <= g - 1'b1;
        end else if (atten_i) begin
          att <= 1'b1;
        end else if (full_i) begin
          att <= 1'b0;
          if (g != TOP) g <= g + 1'b1;
        end else if (fade_up_i) begin
          if (g != TOP) g <= g + 1'b1;
        end else if (fade_dn_i) begin
          if (g != '0) g <= g - 1'b1;
        end
      end
    end
  end

  assign gain_o   = g;
  assign peak_l_o = pk_l[DW-1:DW-8];
  assign peak_r_o = pk_r[DW-1:DW-8];
endmodule

module audio_gain_stage_chk #(parameter int GW = 7) (
  input logic          clk,
  input logic          rst_n,
  input logic          strobe_i,
  input logic          mute_i,
  input logic          atten_i,
  input logic          pk_clr_i,
  input logic [GW-1:0] gain_o,
  input logic [7:0]    peak_l_o,
  input logic [7:0]    peak_r_o
);
  a_r2_hold_no_strobe: assert property (@(posedge clk) disable iff (!rst_n)
    !strobe_i |=> $stable(gain_o));
  a_r2_one_step: assert property (@(posedge clk) disable iff (!rst_n)
    strobe_i |=> ({1'b0, gain_o} == {1'b0, $past(gain_o)} ||
                  {1'b0, gain_o} == {1'b0, $past(gain_o)} + 1'b1 ||
                  {1'b0, gain_o} + 1'b1 == {1'b0, $past(gain_o)}));
  a_r3_mute_down: assert property (@(posedge clk) disable iff (!rst_n)
    (strobe_i && mute_i && gain_o != '0) |=> {1'b0, gain_o} + 1'b1 == {1'b0, $past(gain_o)});
  a_r5_atten_keeps_gain: assert property (@(posedge clk) disable iff (!rst_n)
    (strobe_i && !mute_i && atten_i) |=> $stable(gain_o));
  a_r9_peak_monotone: assert property (@(posedge clk) disable iff (!rst_n)
    !pk_clr_i |=> (peak_l_o >= $past(peak_l_o) && peak_r_o >= $past(peak_r_o)));
  a_r10_clear: assert property (@(posedge clk) disable iff (!rst_n)
    pk_clr_i |=> (peak_l_o == 8'd0 && peak_r_o == 8'd0));
endmodule

bind audio_gain_stage audio_gain_stage_chk #(.GW(GW)) u_chk (
  .clk(clk), .rst_n(rst_n), .strobe_i(strobe_i), .mute_i(mute_i),
  .atten_i(atten_i), .pk_clr_i(pk_clr_i), .gain_o(gain_o),
  .peak_l_o(peak_l_o), .peak_r_o(peak_r_o));

// File: tb/audio_gain_stage_tb.sv
module audio_gain_stage_tb;
  logic clk = 0, rst_n = 0;
  logic strobe_i = 0, mute_i = 0, full_i = 0, atten_i = 0;
  logic fade_up_i = 0, fade_dn_i = 0, pk_clr_i = 0;
  logic signed [15:0] left_i = 0, right_i = 0, left_o, right_o;
  logic [6:0] gain_o;
  logic [7:0] peak_l_o, peak_r_o;

  audio_gain_stage u_dut (.*);

  always #2.5 clk = ~clk;

  int total = 0, bad = 0, cycles = 0;
  longint rom [128];
  int m_g = 127, m_att = 0, m_ol = 0, m_or = 0, m_pl = 0, m_pr = 0;

  function automatic int scl(int x, int g, int att);
    longint y = (longint'(x) * rom[g] + 16384) >>> 15;
    if (att != 0) y = (y * 8231 + 16384) >>> 15;
    return int'(y);
  endfunction

  function automatic int absv(int x);
    return (x < 0) ? -x : x;
  endfunction

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic compare_all();
    chk(int'(left_o) == m_ol, "R8 left", int'(left_o), m_ol);
    chk(int'(right_o) == m_or, "R8 right", int'(right_o), m_or);
    chk(int'(gain_o) == m_g, "R2 gain", int'(gain_o), m_g);
    chk(int'(peak_l_o) == (m_pl >> 8), "R9 peak left", int'(peak_l_o), m_pl >> 8);
    chk(int'(peak_r_o) == (m_pr >> 8), "R9 peak right", int'(peak_r_o), m_pr >> 8);
  endtask

  // drive at negedge, model at posedge, compare at next negedge
  task automatic cyc(input bit st, input int l, input int r, input bit mu,
                     input bit at, input bit fu, input bit up, input bit dn, input bit clr);
    strobe_i = st; left_i = 16'(l); right_i = 16'(r);
    mute_i = mu; atten_i = at; full_i = fu; fade_up_i = up; fade_dn_i = dn; pk_clr_i = clr;
    @(posedge clk);
    if (clr) begin m_pl = 0; m_pr = 0; end
    else if (st) begin
      if (absv(l) > m_pl) m_pl = absv(l);
      if (absv(r) > m_pr) m_pr = absv(r);
    end
    if (st) begin
      m_ol = scl(l, m_g, m_att); m_or = scl(r, m_g, m_att);
      if (mu) begin if (m_g > 0) m_g--; end
      else if (at) m_att = 1;
      else if (fu) begin m_att = 0; if (m_g < 127) m_g++; end
      else if (up) begin if (m_g < 127) m_g++; end
      else if (dn) begin if (m_g > 0) m_g--; end
    end
    @(negedge clk);
    compare_all();
  endtask

  initial begin
    forever begin
      @(posedge clk);
      cycles++;
      if (cycles > 200000) begin
        bad++; total++;
        $display("FAIL watchdog actual=%0d expected<=200000", cycles);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
      end
    end
  end

  initial begin
    rom[127] = 32768;
    for (int k = 127; k >= 2; k--) rom[k-1] = (rom[k] * 65010 + 32768) >> 16;
    rom[0] = 0;

    repeat (3) @(negedge clk);
    chk(gain_o == 7'd127 && left_o == 0 && peak_l_o == 0 && peak_r_o == 0,
        "R1 in reset", int'(gain_o), 127);
    rst_n = 1;
    @(negedge clk);
    compare_all();
    chk(gain_o == 7'd127 && right_o == 0, "R1 after release", int'(gain_o), 127);

    // unity and no-strobe hold
    cyc(1, 16384, -1000, 0, 0, 0, 0, 0, 0);
    chk(int'(left_o) == 16384, "R8 unity", int'(left_o), 16384);
    cyc(0, 999, 999, 1, 0, 0, 0, 1, 0);
    chk(int'(gain_o) == 127 && int'(left_o) == 16384, "R2 no strobe no change", int'(gain_o), 127);
    // saturate at top
    cyc(1, 100, 100, 0, 0, 0, 1, 0, 0);
    chk(int'(gain_o) == 127, "R2 saturate top", int'(gain_o), 127);
    // attenuate
    cyc(1, 16384, 16384, 0, 1, 0, 0, 0, 0);
    chk(int'(gain_o) == 127, "R5 gain unchanged", int'(gain_o), 127);
    cyc(1, 16384, 16384, 0, 0, 0, 0, 0, 0);
    chk(int'(left_o) == 4116, "R5 -12 dB", int'(left_o), 4116);
    // full clears attenuation
    cyc(1, 16384, 16384, 0, 0, 1, 0, 0, 0);
    cyc(1, 16384, 16384, 0, 0, 0, 0, 0, 0);
    chk(int'(left_o) == 16384, "R4 attenuation off", int'(left_o), 16384);
    // fade down sequence, then both fades
    for (int i = 0; i < 27; i++) cyc(1, 20000 - i * 300, -20000 + i * 300, 0, 0, 0, 0, 1, 0);
    chk(int'(gain_o) == 100, "R6 fade down", int'(gain_o), 100);
    cyc(1, 5, 5, 0, 0, 0, 1, 1, 0);
    chk(int'(gain_o) == 101, "R6 both fades up wins", int'(gain_o), 101);
    // priority
    cyc(1, 7000, 7000, 1, 1, 1, 1, 0, 0);
    chk(int'(gain_o) == 100, "R7 mute first", int'(gain_o), 100);
    cyc(1, 7000, 7000, 0, 0, 0, 0, 0, 0);
    chk(int'(left_o) == scl(7000, 100, 0), "R7 attenuate not applied", int'(left_o), scl(7000, 100, 0));
    cyc(1, 7000, 7000, 0, 1, 1, 1, 0, 0);
    chk(int'(gain_o) == 100, "R7 attenuate over full", int'(gain_o), 100);
    cyc(1, 7000, 7000, 0, 0, 1, 0, 1, 0);
    chk(int'(gain_o) == 101, "R7 full over fade", int'(gain_o), 101);
    // mute to zero
    for (int i = 0; i < 130; i++) cyc(1, 32767, -32768, 1, 0, 0, 0, 0, 0);
    chk(int'(gain_o) == 0, "R3 reaches zero", int'(gain_o), 0);
    cyc(1, 32767, -32768, 1, 0, 0, 0, 0, 0);
    chk(left_o == 0 && right_o == 0, "R3 silent output", int'(left_o), 0);
    chk(int'(peak_r_o) == 128, "R9 abs of -32768", int'(peak_r_o), 128);
    // clear beats update
    cyc(1, 30000, 30000, 0, 0, 0, 0, 0, 1);
    chk(peak_l_o == 0 && peak_r_o == 0, "R10 clear priority", int'(peak_l_o), 0);
    // ramp back up
    for (int i = 0; i < 130; i++) cyc(1, -12345, 23456, 0, 0, 1, 0, 0, 0);
    chk(int'(gain_o) == 127, "R4 back to unity", int'(gain_o), 127);
    // random mix
    for (int i = 0; i < 4000; i++) begin
      int cmd = int'($urandom_range(0, 15));
      cyc(($urandom_range(0, 1)) == 1, int'($urandom_range(0, 65535)) - 32768,
          int'($urandom_range(0, 65535)) - 32768,
          cmd == 1, cmd == 2, cmd == 3, cmd == 4 || cmd == 6, cmd >= 5 && cmd <= 7,
          $urandom_range(0, 40) == 0);
    end
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule